// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits between a host bus and the embedded-operation engine of a word-wide NOR flash. It samples one bus write per clock in which `wr_en_i` is high and recognises the multi-cycle unlock command sequences. The recognised commands are word program, sector erase, chip erase, sector lockdown, ID-mode entry, return to read array (which also leaves ID mode), configuration write, and erase suspend and resume. For each command it issues a single-cycle pulse, one clock after the closing write. The pulse carries a command code, the closing write's address and data, and the sector index derived from that address.

The block also reports the device mode: read array, ID mode, busy or suspended. The memory array, the embedded-operation timing and the status bits are kept out of this block. The engine drives `eng_busy_i` while it runs an operation. While a program runs, every write is dropped. While an erase runs, only a suspend write gets through. A suspended erase lets a program into another sector go ahead, and it rejects further erases.

Top module: `nor_cmd_decoder`

## Requirements
- R1: Unlock matching uses only address bits 11:0 and data bits 7:0. The first unlock cycle is data AA at 555h. The second unlock cycle is data 55 at 2AAh or AAAh, because address bit 11 is ignored. Upper address bits and data bits 15:8 never affect matching.
- R2: Unlock, then A0 at 555h, then one more write gives a PROGRAM pulse (`cmd_kind_o`=3) one cycle after that write. The pulse carries the full address and the full 16-bit data of that write.
- R3: Unlock, then 90 at 555h gives ID_ENTER (code 2) and mode ID. A single write of F0 to any address, or unlock then F0 at 555h, gives READ_ARRAY (code 1) and clears ID mode.
- R4: Unlock, then D0 at 555h, then data 00 or 01 gives CFG_WRITE (code 7) and loads `cfg_o` with that value. Any other low byte in that fourth cycle gives no pulse and leaves `cfg_o` unchanged.
- R5: Unlock, then 80 at 555h, then a second unlock, then the sixth cycle selects the command. 10 at 555h gives CHIP_ERASE (code 5). 30 at any address gives SECTOR_ERASE (code 4). 60 at any address gives LOCKDOWN (code 6).
- R6: `cmd_sector_o` is the sector of the closing address, with 8 sectors of 4K words and 31 sectors of 32K words. When TOP_BOOT=0, words 0..7FFFh map to sectors 0..7 and each higher 32K block b maps to b+7. When TOP_BOOT=1, 32K block b maps to b for b<31, and the top 32K maps to 31..38.
- R7: A write that does not match the expected step of a sequence returns the decoder to idle and produces no pulse.
- R8: While `eng_busy_i` is high after a PROGRAM, every write is ignored. No pulse is produced and the sequence state does not advance.
- R9: While an erase runs, only a single B0 write is accepted. It gives SUSPEND (code 8) and mode SUSP. While suspended, a single 30 write gives RESUME (code 9), and erase commands give no pulse.
- R10: `rst_n` low clears the sequence state, ID mode and suspend state, but does not change `cfg_o`. `por_n` low clears `cfg_o` to 00.
- R11: `mode_o` encodes READ=0, ID=1, BUSY=2 and SUSP=3. BUSY shows whenever `eng_busy_i` is high. Otherwise SUSP takes precedence over ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of sequence and mode state |
| por_n | input | 1 | Active-low power-on clear of the configuration value |
| wr_en_i | input | 1 | Bus write strobe, one write per cycle high |
| wr_addr_i | input | 20 | Word address of the write |
| wr_data_i | input | 16 | Write data |
| eng_busy_i | input | 1 | Embedded operation in progress |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_kind_o | output | 4 | Command code |
| cmd_addr_o | output | 20 | Address of the closing write |
| cmd_data_o | output | 16 | Data of the closing write |
| cmd_sector_o | output | 6 | Sector index of the closing address |
| mode_o | output | 2 | Device mode |
| cfg_o | output | 2 | Configuration value |

## Verification
The bench drives unlock prefixes with junk in the upper address and data bits and with the 2AAh alias. A decoder that compared too many bits would miss these sequences. It breaks sequences at the second and fifth cycles and then sends a bare A0 or 30. A decoder that failed to return to idle would emit a spurious program or resume. It holds a partial sequence across a busy program and across a reset, then completes it. A decoder that let writes advance the state in those windows would issue a late command. Sector numbering is checked at both ends of the small-sector region for both boot layouts, because an off-by-one there lands on a neighbouring sector.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int unsigned ADDR_W    = 20;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned MATCH_AW  = 12;
  localparam int unsigned BIG_LOG   = 15;
  localparam int unsigned SMALL_LOG = 12;
  localparam int unsigned CFG_W     = 2;
  localparam int unsigned NBIG      = 1 << (ADDR_W - BIG_LOG);
  localparam int unsigned NSUB      = 1 << (BIG_LOG - SMALL_LOG);
  localparam int unsigned NSEC      = NBIG - 1 + NSUB;
  localparam int unsigned SEC_W     = $clog2(NSEC);

  localparam logic [MATCH_AW-1:0] UNL_ADDR1 = 'h555;
  localparam logic [MATCH_AW-1:0] UNL_ADDR2 = 'h2AA;

  localparam logic [7:0] OP_UNL_A   = 8'hAA;
  localparam logic [7:0] OP_UNL_B   = 8'h55;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_ID      = 8'h90;
  localparam logic [7:0] OP_CFG     = 8'hD0;
  localparam logic [7:0] OP_GROUP   = 8'h80;
  localparam logic [7:0] OP_EXIT    = 8'hF0;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_SECT    = 8'h30;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'h30;

  typedef enum logic [3:0] {
    CMD_NONE       = 4'd0,
    CMD_READ_ARRAY = 4'd1,
    CMD_ID_ENTER   = 4'd2,
    CMD_PROGRAM    = 4'd3,
    CMD_SECT_ERASE = 4'd4,
    CMD_CHIP_ERASE = 4'd5,
    CMD_LOCKDOWN   = 4'd6,
    CMD_CFG_WRITE  = 4'd7,
    CMD_SUSPEND    = 4'd8,
    CMD_RESUME     = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_ID   = 2'd1,
    MODE_BUSY = 2'd2,
    MODE_SUSP = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_CFG, SQ_ER4, SQ_ER5, SQ_ER6
  } seq_e;

  // First unlock address: 555h on the matched bits
  function automatic logic hit_addr1(input logic [ADDR_W-1:0] a);
    return a[MATCH_AW-1:0] == UNL_ADDR1;
  endfunction

  // Second unlock address: 2AAh with the top matched bit ignored
  function automatic logic hit_addr2(input logic [ADDR_W-1:0] a);
    return a[MATCH_AW-2:0] == UNL_ADDR2[MATCH_AW-2:0];
  endfunction

  // Sector index for either boot layout
  function automatic logic [SEC_W-1:0] sector_of(input logic [ADDR_W-1:0] a,
                                                 input logic top);
    int unsigned blk, sub, idx;
    blk = 32'(a[ADDR_W-1:BIG_LOG]);
    sub = 32'(a[BIG_LOG-1:SMALL_LOG]);
    if (top) idx = (blk == NBIG - 1) ? (NBIG - 1 + sub) : blk;
    else     idx = (blk == 0) ? sub : (blk + NSUB - 1);
    return SEC_W'(idx);
  endfunction
endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ign_all_i,
  input  logic              erase_run_i,
  input  logic              susp_i,
  output cmd_e              dec_kind_o,
  output logic              cmd_valid_o,
  output cmd_e              cmd_kind_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [SEC_W-1:0]  cmd_sector_o
);
  seq_e       st_q, st_n;
  cmd_e       dec;
  logic [7:0] lo;
  logic       a1, a2;

  assign lo = wr_data_i[7:0];
  assign a1 = hit_addr1(wr_addr_i);
  assign a2 = hit_addr2(wr_addr_i);

  always_comb begin
    st_n = st_q;
    dec  = CMD_NONE;
    if (wr_en_i && !ign_all_i) begin
      if (erase_run_i) begin
        st_n = SQ_IDLE;
        if (st_q == SQ_IDLE && lo == OP_SUSPEND) dec = CMD_SUSPEND;
      end else begin
        unique case (st_q)
          SQ_IDLE: begin
            if (lo == OP_UNL_A && a1)          st_n = SQ_UNL1;
            else if (lo == OP_EXIT)            dec  = CMD_READ_ARRAY;
            else if (lo == OP_RESUME && susp_i) dec = CMD_RESUME;
          end
          SQ_UNL1: st_n = (lo == OP_UNL_B && a2) ? SQ_UNL2 : SQ_IDLE;
          SQ_UNL2: begin
            st_n = SQ_IDLE;
            if (a1) begin
              case (lo)
                OP_PROG:  st_n = SQ_PROG;
                OP_ID:    dec  = CMD_ID_ENTER;
                OP_CFG:   st_n = SQ_CFG;
                OP_GROUP: st_n = SQ_ER4;
                OP_EXIT:  dec  = CMD_READ_ARRAY;
                default:  st_n = SQ_IDLE;
              endcase
            end
          end
          SQ_PROG: begin
            st_n = SQ_IDLE;
            dec  = CMD_PROGRAM;
          end
          SQ_CFG: begin
            st_n = SQ_IDLE;
            if (lo[7:CFG_W-1] == '0) dec = CMD_CFG_WRITE;
          end
          SQ_ER4: st_n = (lo == OP_UNL_A && a1) ? SQ_ER5 : SQ_IDLE;
          SQ_ER5: st_n = (lo == OP_UNL_B && a2) ? SQ_ER6 : SQ_IDLE;
          SQ_ER6: begin
            st_n = SQ_IDLE;
            if (lo == OP_CHIP && a1 && !susp_i) dec = CMD_CHIP_ERASE;
            else if (lo == OP_SECT && !susp_i)  dec = CMD_SECT_ERASE;
            else if (lo == OP_LOCK)             dec = CMD_LOCKDOWN;
          end
        endcase
      end
    end
  end

  assign dec_kind_o = dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= SQ_IDLE;
      cmd_valid_o  <= 1'b0;
      cmd_kind_o   <= CMD_NONE;
      cmd_addr_o   <= '0;
      cmd_data_o   <= '0;
      cmd_sector_o <= '0;
    end else begin
      st_q        <= st_n;
      cmd_valid_o <= (dec != CMD_NONE);
      cmd_kind_o  <= dec;
      if (dec != CMD_NONE) begin
        cmd_addr_o   <= wr_addr_i;
        cmd_data_o   <= wr_data_i;
        cmd_sector_o <= sector_of(wr_addr_i, TOP_BOOT);
      end
    end
  end

  // R8: a running program lets no write through
  a_r8_busy_program_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ign_all_i |=> !cmd_valid_o);

  // R7: every pulse traces back to a write in the previous cycle
  a_r7_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(wr_en_i));
endmodule

// File: rtl/nor_mode_track.sv
module nor_mode_track
  import nor_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  eng_busy_i,
  input  cmd_e  dec_kind_i,
  output logic  ign_all_o,
  output logic  erase_run_o,
  output logic  susp_o,
  output mode_e mode_o
);
  logic id_q, susp_q, prog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= 1'b0;
      susp_q <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      case (dec_kind_i)
        CMD_ID_ENTER:   id_q <= 1'b1;
        CMD_READ_ARRAY: id_q <= 1'b0;
        CMD_PROGRAM:    prog_q <= 1'b1;
        CMD_SECT_ERASE,
        CMD_CHIP_ERASE: prog_q <= 1'b0;
        CMD_SUSPEND:    susp_q <= 1'b1;
        CMD_RESUME: begin
          susp_q <= 1'b0;
          prog_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign ign_all_o   = eng_busy_i && prog_q;
  assign erase_run_o = eng_busy_i && !prog_q && !susp_q;
  assign susp_o      = susp_q;

  always_comb begin
    if (eng_busy_i)  mode_o = MODE_BUSY;
    else if (susp_q) mode_o = MODE_SUSP;
    else if (id_q)   mode_o = MODE_ID;
    else             mode_o = MODE_READ;
  end

  // R9: suspension only starts from a running erase
  a_r9_susp_from_erase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> $past(erase_run_o));

  // R9: no erase is decoded while suspended
  a_r9_no_erase_in_susp: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> !(dec_kind_i inside {CMD_SECT_ERASE, CMD_CHIP_ERASE}));
endmodule

// File: rtl/nor_cfg_reg.sv
module nor_cfg_reg
  import nor_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  cmd_e             dec_kind_i,
  input  logic [CFG_W-1:0] val_i,
  output logic [CFG_W-1:0] cfg_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          cfg_o <= '0;
    else if (dec_kind_i == CMD_CFG_WRITE) cfg_o <= val_i;
  end

  // R4: value only moves on a decoded configuration write
  a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!por_n)
    (dec_kind_i != CMD_CFG_WRITE) |=> $stable(cfg_o));
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eng_busy_i,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_kind_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [SEC_W-1:0]  cmd_sector_o,
  output logic [1:0]        mode_o,
  output logic [CFG_W-1:0]  cfg_o
);
  cmd_e  dec_kind, kind_q;
  mode_e mode;
  logic  ign_all, erase_run, susp;

  nor_seq_fsm #(.TOP_BOOT(TOP_BOOT)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .ign_all_i    (ign_all),
    .erase_run_i  (erase_run),
    .susp_i       (susp),
    .dec_kind_o   (dec_kind),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_kind_o   (kind_q),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_data_o   (cmd_data_o),
    .cmd_sector_o (cmd_sector_o)
  );

  nor_mode_track u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_busy_i  (eng_busy_i),
    .dec_kind_i  (dec_kind),
    .ign_all_o   (ign_all),
    .erase_run_o (erase_run),
    .susp_o      (susp),
    .mode_o      (mode)
  );

  nor_cfg_reg u_cfg (
    .clk        (clk),
    .por_n      (por_n),
    .dec_kind_i (dec_kind),
    .val_i      (wr_data_i[CFG_W-1:0]),
    .cfg_o      (cfg_o)
  );

  assign cmd_kind_o = kind_q;
  assign mode_o     = mode;
endmodule

// File: tb/tb_nor_cmd_decoder.sv
`timescale 1ns/1ps
module tb_nor_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        wr_en = 1'b0, eng_busy = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cmd_valid, cmd_valid_t;
  logic [3:0]  cmd_kind, cmd_kind_t;
  logic [19:0] cmd_addr, cmd_addr_t;
  logic [15:0] cmd_data, cmd_data_t;
  logic [5:0]  cmd_sector, cmd_sector_t;
  logic [1:0]  mode, mode_t, cfg, cfg_t;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nor_cmd_decoder #(.TOP_BOOT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .eng_busy_i(eng_busy),
    .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind), .cmd_addr_o(cmd_addr),
    .cmd_data_o(cmd_data), .cmd_sector_o(cmd_sector), .mode_o(mode), .cfg_o(cfg));

  nor_cmd_decoder #(.TOP_BOOT(1'b1)) dut_t (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .eng_busy_i(eng_busy),
    .cmd_valid_o(cmd_valid_t), .cmd_kind_o(cmd_kind_t), .cmd_addr_o(cmd_addr_t),
    .cmd_data_o(cmd_data_t), .cmd_sector_o(cmd_sector_t), .mode_o(mode_t), .cfg_o(cfg_t));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_sector(input int a, input bit top);
    if (top) return (a >= 'hF8000) ? 31 + (a - 'hF8000) / 4096 : a / 32768;
    return (a < 'h8000) ? a / 4096 : a / 32768 + 7;
  endfunction

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unl(input bit alias2);
    wr(20'h00555, 16'h00AA);
    wr(alias2 ? 20'h00AAA : 20'h002AA, 16'h0055);
  endtask

  task automatic exp_cmd(input string req, input int kind,
                         input logic [19:0] a, input logic [15:0] d);
    chk(req, "valid", 32'(cmd_valid), 1);
    chk(req, "kind", 32'(cmd_kind), kind);
    chk(req, "addr", 32'(cmd_addr), 32'(a));
    chk(req, "data", 32'(cmd_data), 32'(d));
  endtask

  task automatic exp_none(input string req);
    chk(req, "no pulse", 32'(cmd_valid), 0);
  endtask

  task automatic erase6(input logic [19:0] a, input logic [7:0] op);
    unl(1'b0);
    wr(20'h00555, 16'h0080);
    unl(1'b1);
    wr(a, {8'h00, op});
  endtask

  task automatic t_reset;
    chk("R10", "mode after reset", 32'(mode), 0);
    chk("R10", "valid after reset", 32'(cmd_valid), 0);
    chk("R10", "cfg after por", 32'(cfg), 0);
  endtask

  task automatic t_program;
    wr(20'hFF555, 16'h34AA); exp_none("R1");
    wr(20'h7FAAA, 16'hC355); exp_none("R1");
    wr(20'h33555, 16'h12A0); exp_none("R2");
    wr(20'h12ABC, 16'hBEEF); exp_cmd("R2", 3, 20'h12ABC, 16'hBEEF);
  endtask

  task automatic t_busy_prog;
    eng_busy = 1'b1;
    @(negedge clk);
    chk("R11", "busy mode", 32'(mode), 2);
    wr(20'h00000, 16'h00F0); exp_none("R8");
    wr(20'h00000, 16'h00B0); exp_none("R8");
    wr(20'h00555, 16'h00AA); exp_none("R8");
    eng_busy = 1'b0;
    wr(20'h002AA, 16'h0055);
    wr(20'h00555, 16'h00A0);
    wr(20'h00100, 16'h1234); exp_none("R8 sequence held");
  endtask

  task automatic t_id;
    unl(1'b0); wr(20'h00555, 16'h0090);
    exp_cmd("R3", 2, 20'h00555, 16'h0090);
    chk("R11", "id mode", 32'(mode), 1);
    wr(20'h12345, 16'h77F0); exp_cmd("R3", 1, 20'h12345, 16'h77F0);
    chk("R3", "mode after F0", 32'(mode), 0);
    unl(1'b1); wr(20'h00555, 16'h0090);
    chk("R3", "id again", 32'(mode), 1);
    unl(1'b0); wr(20'h00555, 16'h00F0);
    chk("R3", "three-cycle exit kind", 32'(cmd_kind), 1);
    chk("R3", "mode after exit", 32'(mode), 0);
  endtask

  task automatic t_cfg;
    unl(1'b0); wr(20'h00555, 16'h00D0); wr(20'h00000, 16'h0001);
    exp_cmd("R4", 7, 20'h00000, 16'h0001);
    chk("R4", "cfg loaded", 32'(cfg), 1);
    unl(1'b0); wr(20'h00555, 16'h00D0); wr(20'h00000, 16'h0005);
    exp_none("R4 bad value");
    chk("R4", "cfg kept", 32'(cfg), 1);
    unl(1'b0); wr(20'h00555, 16'h00D0); wr(20'h00000, 16'hFF00);
    chk("R4", "cfg cleared", 32'(cfg), 0);
    unl(1'b0); wr(20'h00555, 16'h00D0); wr(20'h00000, 16'h0001);
  endtask

  task automatic t_erase;
    erase6(20'h03123, 8'h30);
    exp_cmd("R5", 4, 20'h03123, 16'h0030);
    chk("R6", "bottom sector", 32'(cmd_sector), exp_sector('h03123, 0));
    chk("R6", "top sector", 32'(cmd_sector_t), exp_sector('h03123, 1));
    erase6(20'hF9ABC, 8'h30);
    chk("R6", "bottom sector high", 32'(cmd_sector), exp_sector('hF9ABC, 0));
    chk("R6", "top sector high", 32'(cmd_sector_t), exp_sector('hF9ABC, 1));
    erase6(20'h47000, 8'h60);
    exp_cmd("R5", 6, 20'h47000, 16'h0060);
    chk("R6", "lockdown sector", 32'(cmd_sector), exp_sector('h47000, 0));
    erase6(20'h00555, 8'h10);
    exp_cmd("R5", 5, 20'h00555, 16'h0010);
    erase6(20'h00556, 8'h10);
    exp_none("R5 chip wrong addr");
  endtask

  task automatic t_abort;
    wr(20'h00555, 16'h00AA); wr(20'h00554, 16'h0055); exp_none("R7");
    wr(20'h00555, 16'h00A0); exp_none("R7");
    wr(20'h00100, 16'h1234); exp_none("R7");
    unl(1'b0); wr(20'h00555, 16'h0080); wr(20'h00555, 16'h00AA);
    wr(20'h00123, 16'h0055); exp_none("R7");
    wr(20'h03000, 16'h0030); exp_none("R7 bare 30");
  endtask

  task automatic t_suspend;
    erase6(20'h10000, 8'h30);
    chk("R9", "erase launched", 32'(cmd_kind), 4);
    eng_busy = 1'b1;
    wr(20'h00555, 16'h00AA); exp_none("R9 erase running");
    wr(20'h00000, 16'h00B0); exp_cmd("R9", 8, 20'h00000, 16'h00B0);
    eng_busy = 1'b0;
    @(negedge clk);
    chk("R11", "susp mode", 32'(mode), 3);
    erase6(20'h20000, 8'h30); exp_none("R9 erase in suspend");
    unl(1'b0); wr(20'h00555, 16'h00A0); wr(20'h30000, 16'h5555);
    exp_cmd("R9", 3, 20'h30000, 16'h5555);
    eng_busy = 1'b1;
    wr(20'h00000, 16'h0030); exp_none("R8 program in suspend");
    eng_busy = 1'b0;
    @(negedge clk);
    chk("R11", "back to susp", 32'(mode), 3);
    wr(20'h00000, 16'h0030); exp_cmd("R9", 9, 20'h00000, 16'h0030);
    chk("R9", "mode after resume", 32'(mode), 0);
    eng_busy = 1'b1;
    wr(20'h00000, 16'h00B0); chk("R9", "suspend again", 32'(cmd_kind), 8);
    eng_busy = 1'b0;
    wr(20'h00000, 16'h0030); chk("R9", "resume again", 32'(cmd_kind), 9);
  endtask

  task automatic t_rst;
    unl(1'b0); wr(20'h00555, 16'h0090);
    wr(20'h00555, 16'h00AA);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R10", "mode after rst", 32'(mode), 0);
    chk("R10", "cfg kept over rst", 32'(cfg), 1);
    wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0);
    wr(20'h00001, 16'h0002); exp_none("R10 sequence cleared");
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    chk("R10", "cfg after por", 32'(cfg), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_busy_prog();
    t_id();
    t_cfg();
    t_erase();
    t_abort();
    t_suspend();
    t_rst();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule